// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Masked Output Writes and Grouped Interrupt

This block is a general-purpose pin port attached to a simple 32-bit register bus. Software uses it to choose, pin by pin, whether a pin drives or listens. It drives output levels through a masked write: the upper half of the written word names the bits to change, and the lower half gives their new values. Two bits in other words therefore never collide in a read-modify-write race. It also reads back the synchronized levels on the pins.

The upper eight pins share a single active-high interrupt request. Each of those pins is qualified by its own enable bit. A control word holds a block-reset bit and a clock-enable bit, and the rest of the block works only when reset is released and the clock is on. Bringing the block up takes two writes to the control word: reset plus clock first, then clock alone. Writing reset with the clock off parks the block in low-power reset.

Reads return data one cycle after the request, with a valid strobe. Writes take effect at the clock edge on which they are presented.

Top module: `pinport_top`

## Requirements
- R1: After the hardware reset (rst_n low), every register reads 0. pin_oe, pin_out and irq_shared are 0.
- R2: The direction word at byte offset 0x00 is read/write in bits 15:0. A 1 in bit n makes pin n an output (pin_oe[n]=1), and a 0 makes it an input.
- R3: A write to offset 0x08 changes output bit n only when data bit 16+n is 1, and then the bit takes data bit n. A read of 0x08 returns the output latch in bits 15:0 and zero in bits 31:16. pin_out follows the latch.
- R4: A read of offset 0x0C returns the pin levels in bits 15:0 after a two-stage synchronizer. With the default of two stages, a level present before clock edge k can be read from the state sampled at edge k+1.
- R5: The interrupt-enable word at offset 0x10 is read/write in bits 15:0, and bit n belongs to pin n.
- R6: irq_shared is the registered OR, over pins 8 to 15, of the synchronized pin level ANDed with its enable bit. It rises one clock after the synchronized level, so three edges after the pin changes. Pins 0 to 7 never affect it.
- R7: The control word at offset 0x14 is read/write. Bit 1 is block reset and bit 0 is clock enable. It reads back in bits 1:0.
- R8: While control bit 1 is set, the direction, output and interrupt-enable words are cleared and irq_shared is held at 0. The control word itself is kept.
- R9: While control bit 0 is clear, writes to offsets 0x00, 0x08 and 0x10 are ignored. The value read at 0x0C stays at the last sampled levels.
- R10: bus_rvalid is high exactly one cycle after a read (bus_sel=1, bus_wr=0), with bus_rdata valid in that cycle. Unmapped offsets (for example 0x04 and 0x18) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output levels to the pads |
| pin_oe | output | 16 | Per-pin output enable |
| irq_shared | output | 1 | Grouped interrupt request of pins 8 to 15 |

## Verification
The bench builds the block with its defaults: 16 pins, a 32-bit data word, a two-stage synchronizer and the shared group on pins 8 to 15. With these values every pin has a mask bit in the same write word, and the grouped request sits entirely in the upper byte. This makes it possible to show that activity on the lower byte leaves the request untouched. The two-stage depth fixes the pin-to-request delay at three edges, which the bench probes edge by edge.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

   // Word indices (byte offset / 4) of the register map.
   localparam logic [2:0] WIX_DIR   = 3'd0;  // 0x00
   localparam logic [2:0] WIX_OUT   = 3'd2;  // 0x08
   localparam logic [2:0] WIX_LEVEL = 3'd3;  // 0x0C
   localparam logic [2:0] WIX_IEN   = 3'd4;  // 0x10
   localparam logic [2:0] WIX_CTRL  = 3'd5;  // 0x14

   typedef struct packed {
      logic hold_rst;   // bit 1
      logic clk_on;     // bit 0
   } blk_ctrl_t;

endpackage

// File: rtl/pinport_regs.sv
module pinport_regs
   import pinport_pkg::*;
#(
   parameter int PINS   = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [2:0]        wr_wix,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PINS-1:0]   dir_q,
   output logic [PINS-1:0]   out_q,
   output logic [PINS-1:0]   ien_q,
   output blk_ctrl_t         ctrl_q
);

   localparam int MASK_LSB = PINS;

   if (2 * PINS > DATA_W) begin : g_bad_width
      $error("pinport_regs: 2*PINS must fit in DATA_W");
   end

   logic hit_dir, hit_out, hit_ien, hit_ctrl, live;

   assign hit_dir  = wr_stb && (wr_wix == WIX_DIR);
   assign hit_out  = wr_stb && (wr_wix == WIX_OUT);
   assign hit_ien  = wr_stb && (wr_wix == WIX_IEN);
   assign hit_ctrl = wr_stb && (wr_wix == WIX_CTRL);
   assign live     = ctrl_q.clk_on && !ctrl_q.hold_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (hit_ctrl) begin
         ctrl_q <= blk_ctrl_t'(wr_data[1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         ien_q <= '0;
      end else if (ctrl_q.hold_rst) begin
         dir_q <= '0;
         ien_q <= '0;
      end else if (live) begin
         if (hit_dir) dir_q <= wr_data[PINS-1:0];
         if (hit_ien) ien_q <= wr_data[PINS-1:0];
      end
   end

   // One flop per output bit, each guarded by its own mask bit.
   for (genvar n = 0; n < PINS; n++) begin : g_out_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q[n] <= 1'b0;
         end else if (ctrl_q.hold_rst) begin
            out_q[n] <= 1'b0;
         end else if (live && hit_out && wr_data[MASK_LSB + n]) begin
            out_q[n] <= wr_data[n];
         end
      end
   end

   assert_clear_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.hold_rst |=> (dir_q == '0) && (out_q == '0) && (ien_q == '0));

   assert_hold_when_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.clk_on && !ctrl_q.hold_rst) |=> $stable(dir_q) && $stable(out_q) && $stable(ien_q));

   assert_mask_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_out && live) |=>
         (((out_q ^ $past(out_q)) & ~$past(wr_data[MASK_LSB +: PINS])) == '0));

endmodule

// File: rtl/pinport_sync.sv
module pinport_sync #(
   parameter int PINS   = 16,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            clr,
   input  logic [PINS-1:0] pin_in,
   output logic [PINS-1:0] level
);

   if (STAGES < 2) begin : g_bad_depth
      $error("pinport_sync: STAGES must be at least 2");
   end

   logic [PINS-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [PINS-1:0] d;
      if (s == 0) begin : g_first
         assign d = pin_in;
      end else begin : g_next
         assign d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stage_q[s] <= '0;
         else if (clr)    stage_q[s] <= '0;
         else if (run)    stage_q[s] <= d;
      end
   end

   assign level = stage_q[STAGES-1];

   assert_level_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(level));

   assert_level_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0));

endmodule

// File: rtl/pinport_irq.sv
module pinport_irq #(
   parameter int GRP = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           clr,
   input  logic [GRP-1:0] level,
   input  logic [GRP-1:0] enable,
   output logic           irq_q
);

   if (GRP < 1) begin : g_bad_group
      $error("pinport_irq: group must hold at least one pin");
   end

   logic [GRP-1:0] gated;
   for (genvar g = 0; g < GRP; g++) begin : g_gate
      assign gated[g] = level[g] & enable[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    irq_q <= 1'b0;
      else if (clr)  irq_q <= 1'b0;
      else if (run)  irq_q <= |gated;
   end

   assert_irq_low_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !irq_q);

   assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr) |=> (irq_q == 1'b0) || ($past(enable) != '0));

endmodule

// File: rtl/pinport_top.sv
module pinport_top
   import pinport_pkg::*;
#(
   parameter int PINS        = 16,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter int GRP_LO      = 8,
   parameter int GRP_HI      = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic              irq_shared
);

   localparam int GRP = GRP_HI - GRP_LO + 1;

   if (ADDR_W != 5) begin : g_bad_addr
      $error("pinport_top: ADDR_W must be 5");
   end
   if (GRP_HI >= PINS || GRP_LO > GRP_HI) begin : g_bad_grp
      $error("pinport_top: shared group outside pin range");
   end

   logic [2:0]      wix;
   logic            aligned, wr_stb, rd_stb;
   logic [PINS-1:0] dir_q, out_q, ien_q, level;
   blk_ctrl_t       ctrl_q;
   logic            run, clr;

   assign wix     = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign wr_stb  = bus_sel && bus_wr && aligned;
   assign rd_stb  = bus_sel && !bus_wr;
   assign clr     = ctrl_q.hold_rst;
   assign run     = ctrl_q.clk_on;

   pinport_regs #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_wix(wix), .wr_data(bus_wdata),
      .dir_q(dir_q), .out_q(out_q), .ien_q(ien_q), .ctrl_q(ctrl_q)
   );

   pinport_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .pin_in(pin_in), .level(level)
   );

   pinport_irq #(.GRP(GRP)) u_irq (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(clr),
      .level(level[GRP_HI:GRP_LO]), .enable(ien_q[GRP_HI:GRP_LO]), .irq_q(irq_shared)
   );

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (aligned) begin
         unique case (wix)
            WIX_DIR:   rd_mux[PINS-1:0] = dir_q;
            WIX_OUT:   rd_mux[PINS-1:0] = out_q;
            WIX_LEVEL: rd_mux[PINS-1:0] = level;
            WIX_IEN:   rd_mux[PINS-1:0] = ien_q;
            WIX_CTRL:  rd_mux[1:0]      = ctrl_q;
            default:   rd_mux           = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= rd_stb;
         if (rd_stb) bus_rdata <= rd_mux;
      end
   end

   assert_rvalid_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> bus_rvalid);

   assert_no_stray_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> !bus_rvalid);

endmodule

// File: tb/pinport_top_tb.sv
module pinport_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe;
   logic        irq_shared;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   pinport_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_shared(irq_shared)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected item per returned read.
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            check("R10 unexpected read data", 32'h1, 32'h0);
         end else begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      idle(3);
      if (exp_q.size() != 0) check("R10 missing read data", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 pin_oe", {16'h0, pin_oe}, 0);
      check("R1 pin_out", {16'h0, pin_out}, 0);
      check("R1 irq", {31'h0, irq_shared}, 0);
      bus_read(5'h00, 0, "R1 dir");
      bus_read(5'h08, 0, "R1 out");
      bus_read(5'h10, 0, "R1 ien");
      bus_read(5'h14, 0, "R1 ctrl");

      // R7 / R8 bring-up: reset+clock, writes cleared while held
      bus_write(5'h14, 32'h3);
      bus_read(5'h14, 32'h3, "R7 ctrl=3");
      bus_write(5'h00, 32'hFFFF);
      bus_read(5'h00, 0, "R8 dir held clear");
      bus_write(5'h14, 32'h1);
      bus_read(5'h14, 32'h1, "R7 ctrl=1");

      // R2 direction
      bus_write(5'h00, 32'hA5C3);
      bus_read(5'h00, 32'hA5C3, "R2 dir readback");
      check("R2 pin_oe", {16'h0, pin_oe}, 32'hA5C3);

      // R3 masked output writes
      bus_write(5'h08, 32'hFFFF_1234);
      bus_write(5'h08, 32'h00F0_FFFF);
      bus_write(5'h08, 32'h0200_0000);
      bus_write(5'h08, 32'h0000_FFFF);
      bus_read(5'h08, 32'h0000_10F4, "R3 out masked");
      check("R3 pin_out", {16'h0, pin_out}, 32'h10F4);

      // R4 pin levels
      pin_in = 16'h5A3C;
      idle(4);
      bus_read(5'h0C, 32'h5A3C, "R4 level");
      pin_in = 16'hC3A5;
      idle(4);
      bus_read(5'h0C, 32'hC3A5, "R4 level second");

      // R5 interrupt enable
      bus_write(5'h10, 32'hFF00);
      bus_read(5'h10, 32'hFF00, "R5 ien readback");

      // R6 lower pins ignored, timing of upper pin
      pin_in = 16'h00FF;
      idle(5);
      check("R6 low pins no irq", {31'h0, irq_shared}, 0);
      pin_in = 16'h8000;
      idle(2);
      check("R6 irq not before 3 edges", {31'h0, irq_shared}, 0);
      idle(1);
      check("R6 irq after 3 edges", {31'h0, irq_shared}, 1);
      bus_write(5'h10, 32'h0300);
      idle(2);
      check("R6 disabled pin no irq", {31'h0, irq_shared}, 0);
      pin_in = 16'h0200;
      idle(4);
      check("R6 enabled pin 9 irq", {31'h0, irq_shared}, 1);

      // R9 clock off: writes ignored, level frozen
      bus_write(5'h14, 32'h0);
      bus_write(5'h00, 32'hFFFF);
      bus_write(5'h08, 32'hFFFF_FFFF);
      bus_write(5'h10, 32'hFFFF);
      pin_in = 16'h1111;
      idle(4);
      bus_read(5'h00, 32'hA5C3, "R9 dir kept");
      bus_read(5'h08, 32'h10F4, "R9 out kept");
      bus_read(5'h10, 32'h0300, "R9 ien kept");
      bus_read(5'h0C, 32'h0200, "R9 level frozen");

      // R8 low-power reset
      bus_write(5'h14, 32'h2);
      idle(1);
      check("R8 irq low", {31'h0, irq_shared}, 0);
      check("R8 pin_oe clear", {16'h0, pin_oe}, 0);
      bus_read(5'h14, 32'h2, "R8 ctrl kept");
      bus_read(5'h08, 0, "R8 out clear");
      bus_read(5'h10, 0, "R8 ien clear");
      bus_write(5'h14, 32'h3);
      bus_write(5'h14, 32'h1);
      idle(4);
      bus_read(5'h0C, 32'h1111, "R4 level after restart");

      // R10 unmapped
      bus_read(5'h04, 0, "R10 unmapped 0x04");
      bus_read(5'h18, 0, "R10 unmapped 0x18");

      finish_run();
   end

endmodule